// File: doc/BRIEF.md
# Full/Empty Tagged Synchronization Memory

This block is a small word memory for producer/consumer handoff between threads. Each 32-bit data word has one state bit that marks it as full or empty. A consumer can wait for a word to become full and then take it. A producer can fill a word and be warned if it overwrites a value that nobody has consumed. The state bits are not kept next to the data. The four bits that belong to one four-word line sit together in a per-line tag entry, which is stored apart from the data array.

A request carries an opcode, a word address and write data. The response arrives one cycle later and holds the done strobe, the read data and a trap flag. The trap is raised when the word's state breaks the rule of the opcode, and in that case the access is cancelled. Besides the checked load and store variants, the memory offers plain accesses that ignore the state bit and an opcode that marks a single word empty. A synchronous reset returns every word to the empty state.

Top module: `fe_sync_mem`

## Requirements
- R1: The word address splits into a line index (upper bits) and a word-in-line select (low two bits). Each word keeps its own 32-bit data and its own state bit. The four state bits of a line sit in that line's tag entry.
- R2: While `rst` is high at a clock edge, every state bit becomes empty (0), and `rsp_done`, `rsp_trap` and `rsp_rdata` become 0.
- R3: Opcode 2 (check-load) returns the word if it is full and leaves its state unchanged. If the word is empty, it traps.
- R4: Opcode 3 (take-load) returns the word if it is full and marks it empty. If the word is empty, it traps.
- R5: Opcode 4 (fill-store) writes the word and marks it full. It never traps, even if the word is already full.
- R6: Opcode 5 (put-store) writes the word and marks it full if the word is empty. If the word is full, it traps.
- R7: A trapped access changes neither the data word nor its state bit.
- R8: Opcode 0 (plain load) and opcode 1 (plain store) read or write the data without checking or changing the state bit, and they never trap.
- R9: Opcode 6 (mark-empty) sets the word's state to empty and leaves its data unchanged. Opcode 7 (no-op) changes nothing. Neither opcode traps.
- R10: A request accepted at a clock edge produces a one-cycle `rsp_done` pulse in the next cycle, with `rsp_trap` in the same response. `rsp_rdata` holds the word for a load that did not trap and 0 in every other case.
- R11: An access changes only the state bit of the addressed word. The other three bits in the same tag entry are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties every word |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode 0..7 |
| req_addr | input | ADDR_W | Word address: line index in the upper bits, word-in-line in the low bits |
| req_wdata | input | DATA_W | Store data |
| rsp_done | output | 1 | Response strobe, one cycle after the request |
| rsp_trap | output | 1 | The state rule of the opcode was broken; the access was cancelled |
| rsp_rdata | output | DATA_W | Load result, or 0 |

## Verification
The bench builds the memory with four lines of four words, which gives sixteen words. At that size the bench can fill words in several lines, apply reset, and then probe every address with a check-load to confirm that all sixteen state bits were cleared. The bench reuses neighbouring words of one line to show that a tag entry update touches a single bit. It also uses the last address to exercise the top line index and the top word select.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        OP_LOAD       = 3'd0,
        OP_STORE      = 3'd1,
        OP_LOAD_CHECK = 3'd2,
        OP_LOAD_TAKE  = 3'd3,
        OP_STORE_FILL = 3'd4,
        OP_STORE_PUT  = 3'd5,
        OP_MARK_EMPTY = 3'd6,
        OP_NOP        = 3'd7
    } fe_op_e;

    typedef struct packed {
        logic trap;
        logic data_we;
        logic state_we;
        logic state_nx;
        logic rd_en;
    } fe_action_t;

endpackage

// File: rtl/fe_rule.sv
module fe_rule
    import fe_pkg::*;
(
    input  fe_op_e     op,
    input  logic       full,
    output fe_action_t act
);
    always_comb begin
        act = '0;
        unique case (op)
            OP_LOAD: begin
                act.rd_en = 1'b1;
            end
            OP_STORE: begin
                act.data_we = 1'b1;
            end
            OP_LOAD_CHECK: begin
                act.trap  = !full;
                act.rd_en = full;
            end
            OP_LOAD_TAKE: begin
                act.trap     = !full;
                act.rd_en    = full;
                act.state_we = full;
                act.state_nx = 1'b0;
            end
            OP_STORE_FILL: begin
                act.data_we  = 1'b1;
                act.state_we = 1'b1;
                act.state_nx = 1'b1;
            end
            OP_STORE_PUT: begin
                act.trap     = full;
                act.data_we  = !full;
                act.state_we = !full;
                act.state_nx = 1'b1;
            end
            OP_MARK_EMPTY: begin
                act.state_we = 1'b1;
                act.state_nx = 1'b0;
            end
            default: begin
                act = '0;
            end
        endcase
    end
endmodule

// File: rtl/fe_tag_array.sv
module fe_tag_array #(
    parameter int WORDS_PER_LINE = 4,
    parameter int NUM_LINES      = 16,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int WSEL_W = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic              we,
    input  logic              bit_nx,
    output logic              bit_rd
);
    logic [WORDS_PER_LINE-1:0] tags_q [NUM_LINES];
    logic [WORDS_PER_LINE-1:0] tags_d [NUM_LINES];
    logic [WORDS_PER_LINE-1:0] entry_rd;

    assign entry_rd = tags_q[line_idx];
    assign bit_rd   = entry_rd[word_sel];

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            tags_d[i] = tags_q[i];
        end
        if (rst) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                tags_d[i] = '0;
            end
        end else if (we) begin
            tags_d[line_idx][word_sel] = bit_nx;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            tags_q[i] <= tags_d[i];
        end
    end

    AST_RESET_EMPTIES: assert property (@(posedge clk)
        rst |=> (tags_q[0] == '0 && tags_q[NUM_LINES-1] == '0)); // R2

    AST_ENTRY_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!we && !$past(rst)) |=> $stable(tags_q[$past(line_idx)])); // R11
endmodule

// File: rtl/fe_data_array.sv
module fe_data_array #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 64,
    localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [NUM_WORDS];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
    import fe_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int WORDS_PER_LINE = 4,
    parameter int NUM_LINES      = 16,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int WSEL_W = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1,
    localparam int ADDR_W = LINE_W + WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_trap,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              done;
        logic              trap;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    fe_op_e            op;
    fe_action_t        act;
    logic              full_rd;
    logic [DATA_W-1:0] word_rd;
    logic              data_we;
    logic              tag_we;
    logic [LINE_W-1:0] line_idx;
    logic [WSEL_W-1:0] word_sel;

    assign op       = fe_op_e'(req_op);
    assign line_idx = req_addr[ADDR_W-1 -: LINE_W];
    assign word_sel = req_addr[WSEL_W-1:0];
    assign data_we  = req_valid && !rst && act.data_we;
    assign tag_we   = req_valid && act.state_we;

    fe_rule u_rule (
        .op   (op),
        .full (full_rd),
        .act  (act)
    );

    fe_tag_array #(
        .WORDS_PER_LINE (WORDS_PER_LINE),
        .NUM_LINES      (NUM_LINES)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .line_idx (line_idx),
        .word_sel (word_sel),
        .we       (tag_we),
        .bit_nx   (act.state_nx),
        .bit_rd   (full_rd)
    );

    fe_data_array #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_LINES * WORDS_PER_LINE)
    ) u_data (
        .clk   (clk),
        .addr  (req_addr),
        .we    (data_we),
        .wdata (req_wdata),
        .rdata (word_rd)
    );

    always_comb begin
        rsp_d = '0;
        if (!rst && req_valid) begin
            rsp_d.done  = 1'b1;
            rsp_d.trap  = act.trap;
            rsp_d.rdata = act.rd_en ? word_rd : '0;
        end
    end

    always_ff @(posedge clk) begin
        rsp_q <= rsp_d;
    end

    assign rsp_done  = rsp_q.done;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_rdata = rsp_q.rdata;

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done); // R10

    AST_NO_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done); // R10

    AST_TRAP_ONLY_CHECKED: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> ($past(req_op) == 3'd2 || $past(req_op) == 3'd3 ||
                      $past(req_op) == 3'd5)); // R8

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && act.trap) |-> (!data_we && !tag_we)); // R7

    AST_PLAIN_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd0 || req_op == 3'd1 || req_op == 3'd7))
            |-> !tag_we); // R8
endmodule

// File: tb/fe_sync_mem_tb.sv
module fe_sync_mem_tb;
    localparam int DW  = 32;
    localparam int WPL = 4;
    localparam int NL  = 4;
    localparam int AW  = 4;
    localparam int NV  = 26;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_done;
    logic          rsp_trap;
    logic [DW-1:0] rsp_rdata;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fe_sync_mem #(
        .DATA_W         (DW),
        .WORDS_PER_LINE (WPL),
        .NUM_LINES      (NL)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_trap  (rsp_trap),
        .rsp_rdata (rsp_rdata)
    );

    // opcodes: 0 ld, 1 st, 2 check-ld, 3 take-ld, 4 fill-st, 5 put-st, 6 mark-empty, 7 nop
    localparam logic [2:0] V_OP [NV] = '{
        3'd2, 3'd5, 3'd2, 3'd2, 3'd5, 3'd3, 3'd3, 3'd4, 3'd4, 3'd2,
        3'd5, 3'd3, 3'd2, 3'd1, 3'd2, 3'd0, 3'd4, 3'd0, 3'd2, 3'd6,
        3'd2, 3'd0, 3'd7, 3'd2, 3'd5, 3'd3};
    localparam logic [AW-1:0] V_ADDR [NV] = '{
        4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5,
        4'd4, 4'd5, 4'd4, 4'd6, 4'd6, 4'd6, 4'd7, 4'd7, 4'd7, 4'd7,
        4'd7, 4'd7, 4'd4, 4'd4, 4'd15, 4'd15};
    localparam logic [DW-1:0] V_WD [NV] = '{
        32'h0, 32'hA5A50001, 32'h0, 32'h0, 32'h0000DEAD, 32'h0, 32'h0, 32'h00001111, 32'h00002222, 32'h0,
        32'h00004444, 32'h0, 32'h0, 32'h00006666, 32'h0, 32'h0, 32'h00007777, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0000F0F0, 32'h0};
    localparam logic V_TRAP [NV] = '{
        1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [DW-1:0] V_RD [NV] = '{
        32'h0, 32'h0, 32'hA5A50001, 32'hA5A50001, 32'h0, 32'hA5A50001, 32'h0, 32'h0, 32'h0, 32'h00002222,
        32'h0, 32'h00002222, 32'h00004444, 32'h0, 32'h0, 32'h00006666, 32'h0, 32'h00007777, 32'h00007777, 32'h0,
        32'h0, 32'h00007777, 32'h0, 32'h00004444, 32'h0, 32'h0000F0F0};
    localparam string V_REQ [NV] = '{
        "R3", "R6", "R3", "R3", "R7", "R4", "R4", "R5", "R5", "R5",
        "R11", "R4", "R11", "R8", "R8", "R8", "R5", "R8", "R8", "R9",
        "R9", "R9", "R9", "R9", "R1", "R1"};

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at a falling edge; the response is sampled at the next falling edge
    task automatic access(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_op = '0;
        req_addr = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        // R2: response outputs cleared during reset
        chk("R2", {31'd0, rsp_done}, 32'd0);
        chk("R2", {31'd0, rsp_trap}, 32'd0);
        chk("R2", rsp_rdata, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            access(V_OP[i], V_ADDR[i], V_WD[i]);
            chk("R10", {31'd0, rsp_done}, 32'd1);
            chk(V_REQ[i], {31'd0, rsp_trap}, {31'd0, V_TRAP[i]});
            chk(V_REQ[i], rsp_rdata, V_RD[i]);
        end

        // R10: done is a single-cycle pulse
        @(negedge clk);
        chk("R10", {31'd0, rsp_done}, 32'd0);

        // R10: back-to-back requests each get a response
        access(3'd4, 4'd8, 32'h00000808);
        chk("R10", {31'd0, rsp_done}, 32'd1);
        access(3'd2, 4'd8, 32'h0);
        chk("R10", {31'd0, rsp_done}, 32'd1);
        chk("R10", rsp_rdata, 32'h00000808);

        // R2: reset empties every word across all lines
        access(3'd4, 4'd0, 32'h1);
        access(3'd4, 4'd11, 32'hB);
        access(3'd4, 4'd14, 32'hE);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < NL * WPL; a++) begin
            access(3'd2, a[AW-1:0], 32'h0);
            chk("R2", {31'd0, rsp_trap}, 32'd1);
        end

        // R7: a trapped take-load leaves the word empty and the data intact
        access(3'd1, 4'd9, 32'h99999999);
        access(3'd3, 4'd9, 32'h0);
        chk("R7", {31'd0, rsp_trap}, 32'd1);
        access(3'd0, 4'd9, 32'h0);
        chk("R7", rsp_rdata, 32'h99999999);
        access(3'd2, 4'd9, 32'h0);
        chk("R7", {31'd0, rsp_trap}, 32'd1);

        // R11: filling one word leaves the other words of its line empty
        access(3'd5, 4'd12, 32'hC);
        access(3'd2, 4'd13, 32'h0);
        chk("R11", {31'd0, rsp_trap}, 32'd1);
        access(3'd2, 4'd12, 32'h0);
        chk("R11", rsp_rdata, 32'hC);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule